// File: doc/BRIEF.md
# Nine-Bit Asynchronous Frame Transmitter

This block serialises one 11-bit asynchronous frame per host request: a low start bit, eight data bits with the least significant bit first, a ninth bit whose value the host supplies, and a high stop bit. The host presents a byte and a ninth-bit value together with a one-cycle write strobe. A separate free-running divider, outside this block, supplies a one-cycle tick at each rollover of its divide-by-16 count, and every bit boundary on the line falls on one of those ticks. The bit boundaries do not depend on when the write arrives.

The byte and the ninth bit are loaded into a nine-bit shift register. Once the data phase begins, each shift moves the register right by one place. The first shift fills the top position with a one, which acts as a marker, and every later shift fills it with a zero. The frame is complete when the ninth bit is in the output position, the marker is directly above it, and every position above the marker is zero. On that shift the block raises a completion flag and returns to idle. The flag stays set until the host pulses the clear input.

Top module: `uart9_tx`

## Requirements
- R1: After reset the serial line `tx_line` is high and the completion flag `tx_done` is low.
- R2: A write with `load_stb` high while the block is idle is accepted. The start bit (line low) appears after the first `bit_tick` that the block samples on a clock edge after the write edge. A tick sampled on the same edge as the write does not start the frame.
- R3: Each data bit is held for one tick period. After the 2nd through the 9th ticks that follow the write, the line carries byte bits 0 through 7 in that order.
- R4: After the 10th tick that follows the write, the line carries the ninth-bit value written with the byte.
- R5: On the 11th tick that follows the write, the line goes high for the stop bit, `tx_done` goes high on that same edge, and the block becomes idle with the line high.
- R6: The line and the flag change only on clock edges at which `bit_tick` is sampled high. Between ticks they hold their values.
- R7: A high `flag_clr` clears `tx_done` on the next edge. If completion and `flag_clr` occur on the same edge, the flag is set.
- R8: A write that arrives while a frame is pending or in progress is ignored. The current frame goes on with its original data, and no further frame follows it.
- R9: Every frame lasts exactly 11 ticks for all 512 combinations of byte and ninth bit. This includes data whose pattern looks like the completion marker before the first shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse at each rollover of the external divide-by-16 count |
| load_stb | input | 1 | One-cycle host write strobe |
| load_byte | input | 8 | Byte to be sent |
| load_ninth | input | 1 | Value of the ninth bit |
| flag_clr | input | 1 | One-cycle clear of the completion flag |
| tx_line | output | 1 | Serial output; high when idle |
| tx_done | output | 1 | Completion flag, held until cleared |

## Verification
The hardest cases to produce are the ones where host events fall on the same clock edge as a rollover tick. These are a write sampled together with a tick, and a flag clear sampled together with the completing tick. The bench drives the tick from a counter of its own, so it knows in advance which edge will carry a tick. It places each write at an offset to the tick phase that rotates from frame to frame, so every phase is covered across the sweep of all 512 data values. On one chosen frame it asserts the clear exactly on the edge of the 11th tick. Extra writes are injected partway through frames to show that they are ignored.

// File: rtl/uart9_tx_pkg.sv
// Shared types for the nine-bit frame transmitter.
package uart9_tx_pkg;
    // Frame phases: idle, waiting for the first tick, start bit, data/ninth/stop.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_START = 2'd2,
        PH_DATA  = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/uart9_tx_ctrl.sv
// Phase sequencer. It accepts a host write only while idle, waits for the next
// bit tick, spends one tick on the start bit, and then issues one shift per tick
// until the shifter reports the end of the frame.
// Assumes: bit_tick is a single-cycle pulse; frame_end is valid only when
// first_shift is low.
module uart9_tx_ctrl
    import uart9_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_tick,
    input  logic      load_stb,
    input  logic      frame_end,
    output tx_phase_e phase,
    output logic      load_en,
    output logic      shift_en,
    output logic      first_shift,
    output logic      set_done
);
    tx_phase_e phase_q;
    logic      first_q;

    // Decode the strobes for the shifter and the flag from the current phase.
    always_comb begin
        load_en     = load_stb && (phase_q == PH_IDLE);
        shift_en    = bit_tick && (phase_q == PH_DATA);
        first_shift = first_q;
        set_done    = shift_en && frame_end;
        phase       = phase_q;
    end

    // Advance the phase on a write or a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            first_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE:  if (load_en) phase_q <= PH_WAIT;
                PH_WAIT:  if (bit_tick) phase_q <= PH_START;
                PH_START: if (bit_tick) begin
                    phase_q <= PH_DATA;
                    first_q <= 1'b1;
                end
                PH_DATA:  if (bit_tick) begin
                    first_q <= 1'b0;
                    if (frame_end) phase_q <= PH_IDLE;
                end
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_START && $past(phase_q) == PH_WAIT) |-> $past(bit_tick)); // R2

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && phase_q != PH_IDLE) |=> (phase_q != PH_WAIT || $past(phase_q) == PH_WAIT)); // R8
endmodule

// File: rtl/uart9_tx_shifter.sv
// Nine-position shift register. A load places {ninth, byte} with the byte's
// bit 0 in the output position. Each shift moves right by one place and fills
// the top with a 1 on the first shift and a 0 afterwards. The end of the frame
// is the marker directly above the output position with zeros above it.
// Assumes: FRAME_W >= 3; load_en and shift_en are never high together.
module uart9_tx_shifter #(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               shift_en,
    input  logic               first_shift,
    output logic               out_bit,
    output logic               frame_end
);
    localparam int UPPER_W = FRAME_W - 2;

    logic [FRAME_W-1:0] sreg;

    // Detect the marker pattern; it is meaningless before the first shift.
    always_comb begin
        out_bit   = sreg[0];
        frame_end = !first_shift && sreg[1] && (sreg[FRAME_W-1:2] == UPPER_W'(0));
    end

    // Load the word or shift in the fill bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        sreg <= '1;
        else if (load_en)  sreg <= load_word;
        else if (shift_en) sreg <= {first_shift, sreg[FRAME_W-1:1]};
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(sreg)); // R6

    AST_MARKER_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && first_shift) |=> sreg[FRAME_W-1]); // R9
endmodule

// File: rtl/uart9_tx_flag.sv
// Completion flag. It is set by the last shift and cleared by the host;
// a set on the same edge as a clear takes priority.
module uart9_tx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    output logic flag
);
    // Hold the flag until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_in) flag <= 1'b1;
        else if (clr_in) flag <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_in |=> flag); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in && !set_in) |=> !flag); // R7
endmodule

// File: rtl/uart9_tx.sv
// Top level of the nine-bit frame transmitter. It joins the sequencer, the
// shifter and the flag, and selects the line level from the phase: high when
// idle or waiting, low for the start bit, and the shifter output otherwise.
// Assumes: bit_tick comes from a free-running divide-by-16 rollover.
module uart9_tx
    import uart9_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              load_ninth,
    input  logic              flag_clr,
    output logic              tx_line,
    output logic              tx_done
);
    localparam int FRAME_W = DATA_W + 1;

    tx_phase_e phase;
    logic      load_en;
    logic      shift_en;
    logic      first_shift;
    logic      set_done;
    logic      frame_end;
    logic      out_bit;

    uart9_tx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .load_stb    (load_stb),
        .frame_end   (frame_end),
        .phase       (phase),
        .load_en     (load_en),
        .shift_en    (shift_en),
        .first_shift (first_shift),
        .set_done    (set_done)
    );

    uart9_tx_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .load_word   ({load_ninth, load_byte}),
        .shift_en    (shift_en),
        .first_shift (first_shift),
        .out_bit     (out_bit),
        .frame_end   (frame_end)
    );

    uart9_tx_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (set_done),
        .clr_in (flag_clr),
        .flag   (tx_done)
    );

    // Select the line level for the current phase.
    always_comb begin
        case (phase)
            PH_START: tx_line = 1'b0;
            PH_DATA:  tx_line = out_bit;
            default:  tx_line = 1'b1;
        endcase
    end

    AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(bit_tick)); // R5

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !load_stb) |=> $stable(tx_line)); // R6

    AST_LATE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && (phase == PH_START || phase == PH_DATA) && !bit_tick) |=> $stable(tx_line)); // R8
endmodule

// File: tb/test_uart9_tx.sv
`timescale 1ns/1ps
module test_uart9_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       load_stb = 1'b0;
    logic [7:0] load_byte = 8'h00;
    logic       load_ninth = 1'b0;
    logic       flag_clr = 1'b0;
    logic       tx_line;
    logic       tx_done;

    int  checks = 0;
    int  errors = 0;
    int  tcnt = 0;
    bit  tick_at_edge = 1'b0;
    bit  finished = 1'b0;

    uart9_tx i_uart9_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .load_stb   (load_stb),
        .load_byte  (load_byte),
        .load_ninth (load_ninth),
        .flag_clr   (flag_clr),
        .tx_line    (tx_line),
        .tx_done    (tx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: remember whether this edge samples a tick, then advance the tick counter.
    task automatic step();
        tick_at_edge = bit_tick;
        @(posedge clk);
        #1;
        tcnt++;
        bit_tick = ((tcnt % DIV) == 0);
    endtask

    function automatic bit exp_line(input int k, input logic [7:0] b, input logic nb);
        if (k == 0)       return 1'b1;
        else if (k == 1)  return 1'b0;
        else if (k <= 9)  return b[k-2];
        else if (k == 10) return nb;
        else              return 1'b1;
    endfunction

    task automatic run_frame(input logic [7:0] b, input logic nb, input int off,
                             input bit inject, input bit collide);
        int k;
        while ((tcnt % DIV) != off) step();
        load_byte  = b;
        load_ninth = nb;
        load_stb   = 1'b1;
        step();
        load_stb   = 1'b0;
        k = 0;
        chk(tx_line == 1'b1, "R2 line before first tick", int'(tx_line), 1);
        while (k < 11) begin
            if (inject && k == 5) begin
                load_byte  = ~b;
                load_ninth = ~nb;
                load_stb   = 1'b1;
            end
            if (collide && k == 10 && bit_tick) flag_clr = 1'b1;
            step();
            load_stb = 1'b0;
            flag_clr = 1'b0;
            if (tick_at_edge) k++;
            if (k <= 1)
                chk(tx_line == exp_line(k, b, nb), "R2 start bit", int'(tx_line), int'(exp_line(k, b, nb)));
            else if (k <= 9)
                chk(tx_line == exp_line(k, b, nb), "R3 R6 data bit", int'(tx_line), int'(exp_line(k, b, nb)));
            else if (k == 10)
                chk(tx_line == exp_line(k, b, nb), "R4 ninth bit", int'(tx_line), int'(exp_line(k, b, nb)));
            else
                chk(tx_line == 1'b1, "R5 stop bit", int'(tx_line), 1);
            if (k < 11)
                chk(tx_done == 1'b0, "R9 flag early", int'(tx_done), 0);
            else
                chk(tx_done == 1'b1, collide ? "R7 set wins" : "R5 flag set", int'(tx_done), 1);
        end
        for (int i = 0; i < 2*DIV + 1; i++) begin
            step();
            chk(tx_line == 1'b1, "R8 no second frame", int'(tx_line), 1);
            chk(tx_done == 1'b1, "R5 flag held", int'(tx_done), 1);
        end
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk(tx_done == 1'b0, "R7 clear", int'(tx_done), 0);
    endtask

    initial begin
        repeat (3) step();
        chk(tx_line == 1'b1, "R1 line idle", int'(tx_line), 1);
        chk(tx_done == 1'b0, "R1 flag low", int'(tx_done), 0);
        rst_n = 1'b1;
        step();
        chk(tx_line == 1'b1, "R1 line after reset", int'(tx_line), 1);
        chk(tx_done == 1'b0, "R1 flag after reset", int'(tx_done), 0);
        for (int v = 0; v < 512; v++) begin
            run_frame(v[7:0], v[8], v % DIV, (v % 7) == 3, v == 100);
        end
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule